// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

This block sits between a set of interrupt request lines and a small CPU core. Each line has its own enable bit, pending bit, 3-bit urgency and a trigger mode (level or pulse). From the pending, enabled lines it picks the most urgent one and, when that line outranks the handler now running, raises a request with a vector number. The core takes the request with an acknowledge strobe and reports the end of the handler with a done strobe.

Acknowledged handlers go onto an internal active stack. The urgency at the top of that stack sets the bar that any new request has to beat, which gives nesting and preemption. When a handler exits, the next eligible request is offered in the very next cycle, with no return to the idle level between them. Software reaches every field through a single write port with a valid strobe, an address and data, and reads through a combinational read mux.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, no request is raised, no handler is active, and reads of global enable (address 0), line enables (address 1), pending (address 2), mode (address 4) and every urgency field (address 8+n) all return zero.
- R2: Urgency is 3 bits, where 0 is the most urgent and 7 the least. Among lines that are pending, enabled and not active, the most urgent one is offered. When two lines share an urgency, the lower-numbered line wins.
- R3: The vector presented for line n is n + 16, and `irq_prio` shows that line's urgency.
- R4: A request is raised only when the global enable (address 0, bit 0) and the line's enable bit (address 1, bit n) are both set. A pending bit stays stored while its line is disabled.
- R5: An acknowledge while a request is raised clears the dispatched line's pending bit. In the same cycle it pushes the line onto the active stack, so `cur_busy` rises and `cur_prio` takes that line's urgency.
- R6: A request preempts the running handler only when its urgency is strictly more urgent. A request of equal or lower urgency waits.
- R7: A done strobe pops the active stack, and `cur_prio` returns to the preempted handler's urgency. In the cycle after the done, any request that is now eligible is offered directly (tail chaining).
- R8: A level-mode line (mode bit n = 0) does not become pending while its handler is active. If its input is still high when the handler exits, it becomes pending again and is offered again.
- R9: For a pulse-mode line (mode bit n = 1), only rising edges set pending. Any number of edges that arrive while its handler is active collapse into one pending request, which is served once after the exit.
- R10: Writing ones to address 2 sets pending bits and writing ones to address 3 clears them. Both work regardless of the enable bits, so a stale request can be discarded before the line is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N | Interrupt request lines |
| cfg_valid | input | 1 | Register write strobe |
| cfg_addr | input | AW | Register address for both write and read |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Read data for `cfg_addr` (combinational) |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | VEC_W | Vector number of the offered line |
| irq_prio | output | 3 | Urgency of the offered line |
| irq_ack | input | 1 | Core takes the offered request |
| irq_done | input | 1 | Core leaves the current handler |
| cur_busy | output | 1 | At least one handler is active |
| cur_prio | output | 3 | Urgency of the innermost active handler |

## Verification
Most wrong internal state shows up at the ports within one cycle. A bad stack entry or stack pointer shows up as a wrong `cur_prio` just after an acknowledge or a done. It also shows up as a missing or spurious preemption, or as an equal-urgency request that interrupts when it should wait. A wrong active mask or mode bit shows up as a level line that pends during its own handler, or as a pulse line whose edges are counted more than once. Either case becomes visible as a pending read or as an extra request right after the exit. Arbitration faults change which vector comes first in a sweep of urgency permutations and ties.

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int N        = 8,
  parameter int DEPTH    = 8,
  parameter int VEC_BASE = 16,
  parameter int VEC_W    = 8,
  parameter int AW       = 6,
  parameter int DW       = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     irq_in,
  input  logic             cfg_valid,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  output logic [DW-1:0]    cfg_rdata,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic [2:0]       irq_prio,
  input  logic             irq_ack,
  input  logic             irq_done,
  output logic             cur_busy,
  output logic [2:0]       cur_prio
);
  localparam int IW  = (N > 1) ? $clog2(N) : 1;
  localparam int TW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SPW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] A_GIE = AW'(0);
  localparam logic [AW-1:0] A_EN  = AW'(1);
  localparam logic [AW-1:0] A_SET = AW'(2);
  localparam logic [AW-1:0] A_CLR = AW'(3);
  localparam logic [AW-1:0] A_MOD = AW'(4);
  localparam int A_PRI = 8;

  logic          gie;
  logic [N-1:0]  en, pend, pulse_m, irq_q, act;
  logic [2:0]    prio [N];
  logic [IW-1:0] stk_line [DEPTH];
  logic [2:0]    stk_prio [DEPTH];
  logic [SPW-1:0] sp;
  logic [TW-1:0] top_i, push_i;

  logic          win_ok;
  logic [IW-1:0] win_idx;
  logic [2:0]    win_p;
  logic [N-1:0]  cand;

  assign cand = pend & en & ~act;

  always_comb begin
    win_ok  = 1'b0;
    win_idx = '0;
    win_p   = 3'd7;
    for (int i = 0; i < N; i++)
      if (cand[i] && (!win_ok || prio[i] < win_p)) begin
        win_ok  = 1'b1;
        win_idx = IW'(i);
        win_p   = prio[i];
      end
  end

  assign top_i    = TW'(sp - SPW'(1));
  assign push_i   = TW'(sp);
  assign cur_busy = (sp != '0);
  assign cur_prio = cur_busy ? stk_prio[top_i] : 3'd0;

  assign irq_req  = gie && win_ok && (!cur_busy || win_p < cur_prio);
  assign irq_vec  = VEC_W'(VEC_BASE) + VEC_W'(win_idx);
  assign irq_prio = win_p;

  logic push, pop;
  assign push = irq_ack && irq_req && !irq_done;
  assign pop  = irq_done && cur_busy;

  logic [N-1:0] act_n, sw_set, sw_clr, ack_clr, hw_set;

  always_comb begin
    act_n = act;
    if (pop)  act_n[stk_line[top_i]] = 1'b0;
    if (push) act_n[win_idx] = 1'b1;
    ack_clr = '0;
    if (push) ack_clr[win_idx] = 1'b1;
  end

  assign sw_set = (cfg_valid && cfg_addr == A_SET) ? cfg_wdata[N-1:0] : '0;
  assign sw_clr = (cfg_valid && cfg_addr == A_CLR) ? cfg_wdata[N-1:0] : '0;
  assign hw_set = (pulse_m & irq_in & ~irq_q) | (~pulse_m & irq_in & ~act_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie     <= 1'b0;
      en      <= '0;
      pend    <= '0;
      pulse_m <= '0;
      irq_q   <= '0;
      act     <= '0;
      sp      <= '0;
      for (int i = 0; i < N; i++) prio[i] <= 3'd0;
      for (int d = 0; d < DEPTH; d++) begin
        stk_line[d] <= '0;
        stk_prio[d] <= 3'd0;
      end
    end else begin
      irq_q <= irq_in;
      act   <= act_n;
      pend  <= (pend & ~sw_clr & ~ack_clr) | sw_set | hw_set;
      if (cfg_valid) begin
        if (cfg_addr == A_GIE) gie <= cfg_wdata[0];
        if (cfg_addr == A_EN)  en <= cfg_wdata[N-1:0];
        if (cfg_addr == A_MOD) pulse_m <= cfg_wdata[N-1:0];
        for (int i = 0; i < N; i++)
          if (cfg_addr == AW'(A_PRI + i)) prio[i] <= cfg_wdata[2:0];
      end
      if (push) begin
        stk_line[push_i] <= win_idx;
        stk_prio[push_i] <= win_p;
        sp <= sp + SPW'(1);
      end else if (pop) begin
        sp <= sp - SPW'(1);
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      A_GIE:        cfg_rdata = DW'(gie);
      A_EN:         cfg_rdata = DW'(en);
      A_SET, A_CLR: cfg_rdata = DW'(pend);
      A_MOD:        cfg_rdata = DW'(pulse_m);
      default:
        for (int i = 0; i < N; i++)
          if (cfg_addr == AW'(A_PRI + i)) cfg_rdata = DW'(prio[i]);
    endcase
  end

  p_vec_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec >= VEC_W'(VEC_BASE) && irq_vec < VEC_W'(VEC_BASE + N)));

  p_preempt_strict_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && cur_busy) |-> (irq_prio < cur_prio));

  p_ack_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (cur_busy && cur_prio == $past(irq_prio)));

  p_done_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (sp == $past(sp) - SPW'(1)));

  p_stack_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SPW'(DEPTH));
endmodule

// File: tb/nest_irq_ctrl_tb.sv
module nest_irq_ctrl_tb;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq_in = '0;
  logic cfg_valid = 0;
  logic [5:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic irq_req, irq_ack = 0, irq_done = 0, cur_busy;
  logic [7:0] irq_vec;
  logic [2:0] irq_prio, cur_prio;
  int total = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  nest_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .cfg_valid(cfg_valid), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_prio(irq_prio),
    .irq_ack(irq_ack), .irq_done(irq_done), .cur_busy(cur_busy), .cur_prio(cur_prio));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; irq_in = '0; cfg_valid = 0; irq_ack = 0; irq_done = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_valid = 1; cfg_addr = 6'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_valid = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    cfg_addr = 6'(a);
    #1 d = cfg_rdata;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
  endtask

  task automatic done();
    @(negedge clk); irq_done = 1;
    @(negedge clk); irq_done = 0;
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [2:0] p [N];
    bit served [N];
    do_reset();
    cyc();
    // R1 reset state
    chk("R1 req", irq_req, 0);
    chk("R1 busy", cur_busy, 0);
    rd(0, d); chk("R1 gie", d, 0);
    rd(1, d); chk("R1 en", d, 0);
    rd(2, d); chk("R1 pend", d, 0);
    rd(4, d); chk("R1 mode", d, 0);
    for (int n = 0; n < N; n++) begin rd(8 + n, d); chk("R1 prio", d, 0); end

    // R2 R3 R5 R7 sweep: permutations and tie patterns
    for (int k = 0; k < 12; k++) begin
      do_reset();
      for (int n = 0; n < N; n++) begin
        p[n] = (k < 8) ? 3'((n * 3 + k) % 8) : 3'((n / 2 + k) % 4);
        served[n] = 0;
        wr(8 + n, 32'(p[n]));
      end
      wr(2, 32'hFF); wr(1, 32'hFF); wr(0, 1);
      for (int s = 0; s < N; s++) begin
        int best;
        best = -1;
        for (int n = 0; n < N; n++)
          if (!served[n] && (best < 0 || p[n] < p[best])) best = n;
        chk("R2 req", irq_req, 1);
        chk("R3 vec", irq_vec, 32'(best + 16));
        chk("R3 prio", irq_prio, 32'(p[best]));
        ack();
        served[best] = 1;
        chk("R5 busy", cur_busy, 1);
        chk("R5 cur_prio", cur_prio, 32'(p[best]));
        rd(2, d); chk("R5 pend cleared", d[best], 0);
        done();
        chk("R7 popped", cur_busy, 0);
      end
      chk("R7 drained", irq_req, 0);
    end

    // R4 and R10
    do_reset();
    wr(0, 1);
    wr(2, 32'h01);
    chk("R4 disabled no req", irq_req, 0);
    rd(2, d); chk("R4 pend kept", d, 32'h01);
    wr(3, 32'h01);
    rd(2, d); chk("R10 clear", d, 0);
    wr(1, 32'h01);
    chk("R10 no stale req", irq_req, 0);
    wr(0, 0);
    wr(2, 32'h01);
    chk("R4 gie off", irq_req, 0);
    wr(0, 1);
    chk("R4 gie on", irq_req, 1);
    chk("R4 vec", irq_vec, 16);

    // R6 and R7: preemption and tail chaining
    do_reset();
    wr(10, 5); wr(12, 5); wr(14, 1);
    wr(1, 32'hFF); wr(0, 1);
    wr(2, 32'h04);
    chk("R6 first", irq_vec, 18);
    ack();
    wr(2, 32'h10);
    chk("R6 equal waits", irq_req, 0);
    wr(2, 32'h40);
    chk("R6 preempt req", irq_req, 1);
    chk("R6 preempt vec", irq_vec, 22);
    ack();
    chk("R6 nested prio", cur_prio, 1);
    chk("R6 no req", irq_req, 0);
    done();
    chk("R7 resume prio", cur_prio, 5);
    chk("R7 resume busy", cur_busy, 1);
    chk("R7 still waits", irq_req, 0);
    done();
    chk("R7 tail chain req", irq_req, 1);
    chk("R7 tail chain vec", irq_vec, 20);
    ack(); done();
    chk("R7 idle", cur_busy, 0);

    // R8 level re-pend
    do_reset();
    wr(11, 2); wr(1, 32'h08); wr(0, 1);
    irq_in[3] = 1;
    cyc();
    chk("R8 req", irq_req, 1);
    chk("R8 vec", irq_vec, 19);
    ack();
    rd(2, d); chk("R8 no pend while active", d, 0);
    chk("R8 no req while active", irq_req, 0);
    done();
    chk("R8 repend req", irq_req, 1);
    chk("R8 repend vec", irq_vec, 19);
    ack();
    irq_in[3] = 0;
    done();
    chk("R8 low no req", irq_req, 0);
    rd(2, d); chk("R8 low no pend", d, 0);

    // R9 pulse collapse
    do_reset();
    wr(4, 32'h20); wr(13, 4); wr(1, 32'h20); wr(0, 1);
    irq_in[5] = 1; cyc(); irq_in[5] = 0; cyc();
    chk("R9 req", irq_req, 1);
    chk("R9 vec", irq_vec, 21);
    ack();
    rd(2, d); chk("R9 pend cleared", d, 0);
    for (int e = 0; e < 3; e++) begin irq_in[5] = 1; cyc(); irq_in[5] = 0; cyc(); end
    rd(2, d); chk("R9 one pend", d, 32'h20);
    chk("R9 no req while active", irq_req, 0);
    done();
    chk("R9 served again", irq_req, 1);
    ack();
    chk("R9 collapsed", irq_req, 0);
    done();
    chk("R9 single service", irq_req, 0);
    chk("R9 idle", cur_busy, 0);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule